// File: doc/BRIEF.md
# Filled triangle span rasterizer

This block turns three pre-sorted triangle vertices into a stream of pixel write requests. The top vertex A, middle vertex B and bottom vertex C arrive with non-decreasing Y, as signed 12-bit coordinates. Two integer edge tracers run in step, one scanline at a time. The long tracer follows A to C. The short tracer follows A to B and is then reloaded at B to follow B to C.

For each scanline the block first lets both tracers walk every pixel they visit on that row and records the leftmost and rightmost X of each. It then emits one run of pixels, from the smallest X found to the largest, in increasing X order. Rows are processed from the top of the triangle to the bottom, so every covered pixel is requested exactly once and the stream stays friendly to burst memory writes.

An outline mode narrows the interior rows to the pixels the edges themselves cover. Pixels leave on a ready/valid handshake. A one-cycle completion pulse follows the acceptance of the last pixel.

Top module: `tri_span_raster`

## Requirements
- R1: After reset, `busy`, `pix_valid` and `done` are low.
- R2: A triangle produces rows from A's Y to C's Y in increasing order, with exactly one run per row. Within a row, pixel X increases by one, or jumps forward in outline mode. No pixel is requested twice.
- R3: Each edge is traced with integer error stepping. The error starts at dx−dy, where dx=|x1−x0| and dy=y1−y0. On each step, X moves one toward x1 when twice the error is at least −dy, and Y moves down one when twice the error is at most dx. In fill mode, row y covers every X from the minimum to the maximum of the traced X values of both edges on that row. The short edge is A→B followed by B→C; the long edge is A→C.
- R4: The short tracer is reloaded at B, and tracing continues on B's row without restarting the long tracer. When A and B share a Y, tracing starts directly on B→C.
- R5: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_x` and `pix_y` hold their values.
- R6: With `outline` high, the top and bottom rows are emitted in full. Every other row emits only those X values that lie inside the short edge's X extent or the long edge's X extent on that row.
- R7: `done` is high for exactly one cycle, in the cycle after the last pixel of the bottom row is accepted. `busy` is low in that cycle.
- R8: A `start` while `busy` is high is ignored. The triangle in progress completes unchanged.
- R9: Negative coordinates are handled as two's-complement signed values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a triangle; vertices and mode are captured in this cycle |
| outline | input | 1 | 1 selects outline drawing, 0 selects filled drawing |
| ax | input | 12 | Top vertex X, signed |
| ay | input | 12 | Top vertex Y, signed |
| bx | input | 12 | Middle vertex X, signed |
| by | input | 12 | Middle vertex Y, signed |
| cx | input | 12 | Bottom vertex X, signed |
| cy | input | 12 | Bottom vertex Y, signed |
| pix_ready | input | 1 | Downstream accepts the current pixel |
| busy | output | 1 | A triangle is in progress |
| pix_valid | output | 1 | A pixel request is presented |
| pix_x | output | 12 | Pixel X, signed |
| pix_y | output | 12 | Pixel Y, signed |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is B's own row. There the short tracer ends one segment and is reloaded, and the two shallow runs must merge with the long edge's run without a gap or a duplicate pixel. A flat top, which skips the first segment entirely, adds a second variant of that hand-over. A sweep over every vertex X from a small signed set, combined with every Y ordering inside four rows, places B on the first, middle and last rows in both modes. A pseudo-random ready pattern stalls the output on first, middle and last pixels alike. Separate runs cover a wide shallow triangle, a single-row triangle, and a second start issued mid-run.

// File: rtl/tri_raster_pkg.sv
package tri_raster_pkg;
  localparam int CW = 12;
  localparam int EW = CW + 3;

  typedef logic signed [CW-1:0] coord_t;
  typedef logic signed [EW-1:0] err_t;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_SPAN} rstate_e;

  typedef struct packed {
    err_t err;
    logic xmove;
    logic ymove;
  } bres_t;

  localparam coord_t C_ONE = coord_t'(1);
  localparam coord_t C_MAX = {1'b0, {(CW-1){1'b1}}};
  localparam coord_t C_MIN = {1'b1, {(CW-1){1'b0}}};

  function automatic err_t abs_diff(coord_t to, coord_t from);
    err_t d;
    d = err_t'(to) - err_t'(from);
    return (d < 0) ? -d : d;
  endfunction

  // One step of the integer error tracer.
  function automatic bres_t bres_step(err_t err, err_t dx, err_t dy);
    bres_t r;
    err_t  e2;
    e2      = err <<< 1;
    r.xmove = (e2 >= -dy);
    r.ymove = (e2 <= dx);
    r.err   = err - (r.xmove ? dy : err_t'(0)) + (r.ymove ? dx : err_t'(0));
    return r;
  endfunction

  function automatic coord_t cmin(coord_t a, coord_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic coord_t cmax(coord_t a, coord_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic in_run(coord_t v, coord_t lo, coord_t hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Next X in a row; in outline rows a gap between the two edge runs is skipped.
  function automatic coord_t next_pixel(coord_t x, coord_t l1, coord_t r1,
                                        coord_t l2, coord_t r2, logic edges_only);
    coord_t nx;
    nx = x + C_ONE;
    if (edges_only && !in_run(nx, l1, r1) && !in_run(nx, l2, r2))
      nx = cmax(l1, l2);
    return nx;
  endfunction
endpackage

// File: rtl/tri_edge_walker.sv
module tri_edge_walker import tri_raster_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  coord_t x0,
  input  coord_t y0,
  input  coord_t x1,
  input  coord_t y1,
  input  logic   adv,
  output coord_t cur_x,
  output coord_t cur_y,
  output logic   at_end
);
  coord_t ex, ey;
  err_t   err, dx, dy;
  logic   sx_neg;
  bres_t  st;

  assign at_end = (cur_x == ex) && (cur_y == ey);
  assign st     = bres_step(err, dx, dy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x  <= '0;
      cur_y  <= '0;
      ex     <= '0;
      ey     <= '0;
      err    <= '0;
      dx     <= '0;
      dy     <= '0;
      sx_neg <= 1'b0;
    end else if (load) begin
      cur_x  <= x0;
      cur_y  <= y0;
      ex     <= x1;
      ey     <= y1;
      dx     <= abs_diff(x1, x0);
      dy     <= err_t'(y1) - err_t'(y0);
      err    <= abs_diff(x1, x0) - (err_t'(y1) - err_t'(y0));
      sx_neg <= (x1 < x0);
    end else if (adv && !at_end) begin
      if (st.xmove) cur_x <= sx_neg ? (cur_x - C_ONE) : (cur_x + C_ONE);
      if (st.ymove) cur_y <= cur_y + C_ONE;
      err <= st.err;
    end
  end
endmodule

// File: rtl/tri_span_gen.sv
module tri_span_gen import tri_raster_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   span_go,
  input  coord_t left,
  input  coord_t right,
  input  coord_t l1,
  input  coord_t r1,
  input  coord_t l2,
  input  coord_t r2,
  input  logic   edges_only,
  input  logic   ready,
  output logic   valid,
  output coord_t x,
  output logic   last
);
  logic active;

  assign valid = active;
  assign last  = (x == right);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      x      <= '0;
    end else if (span_go) begin
      active <= 1'b1;
      x      <= left;
    end else if (active && ready) begin
      if (last) active <= 1'b0;
      else      x <= next_pixel(x, l1, r1, l2, r2, edges_only);
    end
  end
endmodule

// File: rtl/tri_span_raster.sv
module tri_span_raster import tri_raster_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 outline,
  input  logic signed [CW-1:0] ax,
  input  logic signed [CW-1:0] ay,
  input  logic signed [CW-1:0] bx,
  input  logic signed [CW-1:0] by,
  input  logic signed [CW-1:0] cx,
  input  logic signed [CW-1:0] cy,
  input  logic                 pix_ready,
  output logic                 busy,
  output logic                 pix_valid,
  output logic signed [CW-1:0] pix_x,
  output logic signed [CW-1:0] pix_y,
  output logic                 done
);
  localparam int NW = 2;  // walker 0: short edge, walker 1: long edge

  rstate_e state;
  coord_t  row, ay_q, bx_q, by_q, cx_q, cy_q;
  logic    outline_q, seg;
  logic    fin [NW];
  coord_t  lo  [NW];
  coord_t  hi  [NW];

  coord_t  wx [NW];
  coord_t  wy [NW];
  coord_t  lx0 [NW];
  coord_t  ly0 [NW];
  coord_t  lx1 [NW];
  coord_t  ly1 [NW];
  logic    wend [NW];
  logic    wload [NW];
  logic    wadv [NW];
  logic    act [NW];

  logic    start_go, seg_switch, row_ready, row_accept_last, final_accept;
  logic    edges_only, span_last;
  coord_t  left, right;

  assign start_go = (state == S_IDLE) && start;

  genvar g;
  generate
    for (g = 0; g < NW; g++) begin : g_walk
      assign act[g]  = (state == S_SCAN) && !fin[g] && (wy[g] == row);
      assign wadv[g] = act[g] && !wend[g];
      tri_edge_walker u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wload[g]),
        .x0     (lx0[g]),
        .y0     (ly0[g]),
        .x1     (lx1[g]),
        .y1     (ly1[g]),
        .adv    (wadv[g]),
        .cur_x  (wx[g]),
        .cur_y  (wy[g]),
        .at_end (wend[g])
      );
    end
  endgenerate

  // short edge reaches B: reload it onto B->C
  assign seg_switch = act[0] && wend[0] && !seg;

  always_comb begin
    wload[0] = start_go || seg_switch;
    if (start_go && (ay != by)) begin
      lx0[0] = ax;  ly0[0] = ay;  lx1[0] = bx;  ly1[0] = by;
    end else if (start_go) begin
      lx0[0] = bx;  ly0[0] = by;  lx1[0] = cx;  ly1[0] = cy;
    end else begin
      lx0[0] = bx_q; ly0[0] = by_q; lx1[0] = cx_q; ly1[0] = cy_q;
    end
    wload[1] = start_go;
    lx0[1] = ax;  ly0[1] = ay;  lx1[1] = cx;  ly1[1] = cy;
  end

  assign row_ready  = (state == S_SCAN) && !act[0] && !act[1];
  assign left       = cmin(lo[0], lo[1]);
  assign right      = cmax(hi[0], hi[1]);
  assign edges_only = outline_q && (row != ay_q) && (row != cy_q);

  tri_span_gen u_span (
    .clk        (clk),
    .rst_n      (rst_n),
    .span_go    (row_ready),
    .left       (left),
    .right      (right),
    .l1         (lo[0]),
    .r1         (hi[0]),
    .l2         (lo[1]),
    .r2         (hi[1]),
    .edges_only (edges_only),
    .ready      (pix_ready),
    .valid      (pix_valid),
    .x          (pix_x),
    .last       (span_last)
  );

  assign pix_y           = row;
  assign busy            = (state != S_IDLE);
  assign row_accept_last = (state == S_SPAN) && pix_valid && pix_ready && span_last;
  assign final_accept    = row_accept_last && (row == cy_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      row       <= '0;
      ay_q      <= '0;
      bx_q      <= '0;
      by_q      <= '0;
      cx_q      <= '0;
      cy_q      <= '0;
      outline_q <= 1'b0;
      seg       <= 1'b0;
      done      <= 1'b0;
      for (int i = 0; i < NW; i++) begin
        fin[i] <= 1'b0;
        lo[i]  <= C_MAX;
        hi[i]  <= C_MIN;
      end
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          row       <= ay;
          ay_q      <= ay;
          bx_q      <= bx;
          by_q      <= by;
          cx_q      <= cx;
          cy_q      <= cy;
          outline_q <= outline;
          seg       <= (ay == by);
          for (int i = 0; i < NW; i++) begin
            fin[i] <= 1'b0;
            lo[i]  <= C_MAX;
            hi[i]  <= C_MIN;
          end
          state <= S_SCAN;
        end
        S_SCAN: begin
          for (int i = 0; i < NW; i++) begin
            if (act[i]) begin
              lo[i] <= cmin(lo[i], wx[i]);
              hi[i] <= cmax(hi[i], wx[i]);
              if (wend[i] && !((i == 0) && !seg)) fin[i] <= 1'b1;
            end
          end
          if (seg_switch) seg <= 1'b1;
          if (row_ready) state <= S_SPAN;
        end
        S_SPAN: if (row_accept_last) begin
          if (final_accept) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            row <= row + C_ONE;
            for (int i = 0; i < NW; i++) begin
              lo[i] <= C_MAX;
              hi[i] <= C_MIN;
            end
            state <= S_SCAN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tri_span_raster_chk.sv
module tri_span_raster_chk import tri_raster_pkg::*; (
  input logic   clk,
  input logic   rst_n,
  input logic   busy,
  input logic   pix_valid,
  input logic   pix_ready,
  input coord_t pix_x,
  input coord_t pix_y,
  input logic   done,
  input logic   seg_switch,
  input coord_t short_y,
  input coord_t mid_y
);
  coord_t prev_x, prev_y;
  logic   have_prev, order_ok;

  assign order_ok = ((pix_y == prev_y) && (pix_x > prev_x)) ||
                    (pix_y == coord_t'(prev_y + C_ONE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_x    <= '0;
      prev_y    <= '0;
    end else if (pix_valid && pix_ready) begin
      have_prev <= 1'b1;
      prev_x    <= pix_x;
      prev_y    <= pix_y;
    end else if (done) begin
      have_prev <= 1'b0;
    end
  end

  a_r1_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> busy);

  a_r2_raster_order: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && have_prev) |-> order_ok);

  a_r4_switch_at_b: assert property (@(posedge clk) disable iff (!rst_n)
    seg_switch |-> (short_y == mid_y));

  a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y)));

  a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pix_valid && pix_ready));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind tri_span_raster tri_span_raster_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .done       (done),
  .seg_switch (seg_switch),
  .short_y    (wy[0]),
  .mid_y      (by_q)
);

// File: tb/tri_span_raster_bench.sv
`timescale 1ns/1ps
module tri_span_raster_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic outline = 1'b0;
  logic signed [11:0] ax = '0, ay = '0, bx = '0, by = '0, cx = '0, cy = '0;
  logic pix_ready = 1'b0;
  logic busy, pix_valid, done;
  logic signed [11:0] pix_x, pix_y;

  always #5 clk = ~clk;

  tri_span_raster u_tri_span_raster (
    .clk(clk), .rst_n(rst_n), .start(start), .outline(outline),
    .ax(ax), .ay(ay), .bx(bx), .by(by), .cx(cx), .cy(cy),
    .pix_ready(pix_ready), .busy(busy), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .done(done)
  );

  int checks = 0, failures = 0, cyc = 0, last_log_cyc = -10;
  int exp_x [4096];
  int exp_y [4096];
  int got_x [4096];
  int got_y [4096];
  int exp_n = 0, got_n = 0;
  int lo_e [2][128];
  int hi_e [2][128];
  bit stall_en = 1'b0, done_seen = 1'b0, wd_hit = 1'b0, held = 1'b0;
  int held_x = 0, held_y = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // integer edge tracing as stated in R3, recording the X extent per row
  task automatic mark(int x0, int y0, int x1, int y1, int e, int base);
    int dx, dy, sx, err, x, y, e2;
    dx = (x1 > x0) ? x1 - x0 : x0 - x1;
    dy = y1 - y0;
    sx = (x1 < x0) ? -1 : 1;
    err = dx - dy; x = x0; y = y0;
    for (int k = 0; k < 10000; k++) begin
      if (x < lo_e[e][y-base]) lo_e[e][y-base] = x;
      if (x > hi_e[e][y-base]) hi_e[e][y-base] = x;
      if (x == x1 && y == y1) break;
      e2 = 2 * err;
      if (e2 >= -dy) begin err -= dy; x += sx; end
      if (e2 <= dx)  begin err += dx; y += 1;  end
    end
  endtask

  task automatic build(int xa, int ya, int xb, int yb, int xc, int yc, bit outl);
    int nr, l, r;
    nr = yc - ya + 1;
    for (int i = 0; i < nr; i++) begin
      lo_e[0][i] = 99999; hi_e[0][i] = -99999;
      lo_e[1][i] = 99999; hi_e[1][i] = -99999;
    end
    if (ya != yb) mark(xa, ya, xb, yb, 0, ya);
    mark(xb, yb, xc, yc, 0, ya);
    mark(xa, ya, xc, yc, 1, ya);
    exp_n = 0;
    for (int i = 0; i < nr; i++) begin
      l = (lo_e[0][i] < lo_e[1][i]) ? lo_e[0][i] : lo_e[1][i];
      r = (hi_e[0][i] > hi_e[1][i]) ? hi_e[0][i] : hi_e[1][i];
      for (int x = l; x <= r; x++) begin
        if (!outl || i == 0 || i == nr - 1 ||
            (x >= lo_e[0][i] && x <= hi_e[0][i]) ||
            (x >= lo_e[1][i] && x <= hi_e[1][i])) begin
          exp_x[exp_n] = x; exp_y[exp_n] = ya + i; exp_n++;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pix_valid && held)
      check(int'(pix_x) == held_x && int'(pix_y) == held_y, "R5", "held pixel x", int'(pix_x), held_x);
    else if (held)
      check(pix_valid, "R5", "valid dropped under stall", int'(pix_valid), 1);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pix_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    held = pix_valid && !pix_ready;
    held_x = int'(pix_x); held_y = int'(pix_y);
    if (pix_valid && pix_ready) begin
      if (got_n < 4096) begin
        got_x[got_n] = int'(pix_x); got_y[got_n] = int'(pix_y);
      end
      got_n++;
      last_log_cyc = cyc;
    end
    if (done) begin
      done_seen = 1'b1;
      check(last_log_cyc == cyc - 1, "R7", "cycles from last accept to done", cyc - last_log_cyc, 1);
      check(!busy, "R7", "busy at done", int'(busy), 0);
    end
    if (cyc > 190000 && !wd_hit) begin
      wd_hit = 1'b1;
      checks++; failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 190000);
    end
  end

  task automatic drive(int xa, int ya, int xb, int yb, int xc, int yc, bit outl);
    ax = 12'(xa); ay = 12'(ya); bx = 12'(xb); by = 12'(yb); cx = 12'(xc); cy = 12'(yc);
    outline = outl;
  endtask

  task automatic run(int xa, int ya, int xb, int yb, int xc, int yc,
                     bit outl, bit stall, bit poke, string tag);
    int mism;
    if (wd_hit) return;
    build(xa, ya, xb, yb, xc, yc, outl);
    got_n = 0; done_seen = 1'b0; stall_en = stall;
    @(negedge clk); drive(xa, ya, xb, yb, xc, yc, outl); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      check(busy, "R8", "busy before second start", int'(busy), 1);
      drive(0, 0, 9, 1, -9, 2, !outl); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done_seen && !wd_hit) @(negedge clk);
    @(negedge clk);
    check(!done, "R7", "done after its pulse", int'(done), 0);
    check(!busy, "R8", "busy after completion", int'(busy), 0);
    check(got_n == exp_n, "R2", "pixel count", got_n, exp_n);
    mism = -1;
    for (int i = 0; i < got_n && i < exp_n && i < 4096; i++)
      if (mism < 0 && (got_x[i] != exp_x[i] || got_y[i] != exp_y[i])) mism = i;
    if (mism >= 0)
      check(1'b0, tag, $sformatf("pixel %0d x (y got %0d exp %0d)", mism, got_y[mism], exp_y[mism]),
            got_x[mism], exp_x[mism]);
    else
      check(1'b1, tag, "pixel sequence", 0, 0);
  endtask

  initial begin
    int xs [4] = '{-3, 0, 2, 5};
    repeat (3) @(negedge clk);
    check(!busy, "R1", "busy after reset", int'(busy), 0);
    check(!pix_valid, "R1", "pix_valid after reset", int'(pix_valid), 0);
    check(!done, "R1", "done after reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !pix_valid, "R1", "idle after reset release", int'(busy), 0);

    // directed shapes
    run(0, 0, 20, 1, -15, 3, 1'b0, 1'b0, 1'b0, "R3");
    run(-40, -5, 30, -2, 5, 6, 1'b0, 1'b1, 1'b0, "R9");
    run(-40, -5, 30, -2, 5, 6, 1'b1, 1'b0, 1'b0, "R6");
    run(3, 2, -2, 2, 6, 2, 1'b0, 1'b1, 1'b0, "R4");
    run(-7, -3, 8, -3, 1, 4, 1'b1, 1'b1, 1'b0, "R4");
    run(-30, 0, 25, 3, -10, 9, 1'b0, 1'b1, 1'b1, "R8");

    // near-exhaustive sweep over a small signed grid in both modes
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int k = 0; k < 4; k++)
            for (int yb = 0; yb < 4; yb++)
              for (int yc = yb; yc < 4; yc++)
                run(xs[i], 0, xs[j], yb, xs[k], yc, m[0], 1'b1, 1'b0,
                    m[0] ? "R6" : ((yb == 0) ? "R4" : "R3"));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule